// File: doc/BRIEF.md
# Booth Partial-Product Generator with Upper-Row Freezing

This block is the front end of a signed multiplier. It takes a two's-complement multiplicand and multiplier, recodes the multiplier into overlapping three-bit windows and, for every window, picks zero, one or two times the multiplicand, possibly negated, as one partial-product row. A 16-bit multiplier gives eight rows. Each row is sign-extended to the full product width and already shifted to its weight, so a downstream compressor only has to add the rows and the per-row correction bits.

A detector looks only at the multiplier. When the high rows are certain to be zero, it stops the operand registers that feed those row selectors from loading, so the selection logic of those rows does not switch. Freezing happens at two levels: the top four rows, or only the top two. A frozen row shows an all-zero partial product, so the product formed from the outputs is exact at all times. Operands are registered on the clock, and the rows appear one cycle later.

Top module: `booth_ppgen`

## Requirements
- R1: Row i (i = 0 to 7) is driven by the multiplier window {y[2i+1], y[2i], y[2i-1]}, where y[-1] is taken as 0, and carries weight 4^i.
- R2: A window decodes to digit -2*b2 + b1 + b0, where b2 is its top bit: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, 101 and 110 give -1.
- R3: A row with a positive digit d equals d*X, sign-extended to 32 bits and shifted left by 2i, with neg_bits[i]=0. A row with a negative digit d equals the bitwise inverse of the sign-extended |d|*X, shifted left by 2i, with neg_bits[i]=1. A zero digit gives an all-zero row with neg_bits[i]=0.
- R4: The sum of all pp_rows[i] plus neg_bits[i]*4^i, taken modulo 2^32, equals X*Y as signed numbers, whether or not rows are frozen.
- R5: Outputs reflect the operands sampled at the previous rising clock edge and do not change between edges.
- R6: When y[15:7] are all equal in a sampled multiplier, gate_wide is 1 in the next cycle and rows 4 to 7 read zero with neg bits 0.
- R7: When y[15:11] are all equal but y[15:7] are not, gate_narrow is 1 in the next cycle, rows 6 and 7 read zero with neg bits 0, and rows 4 and 5 keep their normal values.
- R8: gate_wide and gate_narrow are never 1 together.
- R9: During reset, all rows, all neg bits and both flags are zero.
- R10: A row that leaves the frozen state shows the value for the newly sampled operands in the same cycle that the flags drop, with no stale content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mcand | input | 16 | Multiplicand X, two's complement |
| mplier | input | 16 | Multiplier Y, two's complement |
| pp_rows | output | 8x32 | Weighted, sign-extended partial-product rows |
| neg_bits | output | 8 | Per-row +1 correction for negative digits, weight 4^i |
| gate_wide | output | 1 | Rows 4 to 7 frozen |
| gate_narrow | output | 1 | Only rows 6 and 7 frozen |

## Verification
A bad freeze enable or a held register that fails to reload shows up at the ports in the first cycle after the multiplier leaves a sign-extended range, as a wrong upper row and a wrong reconstructed product. A decode slip gives a wrong row and a wrong sum in the cycle after the operands are sampled. The bench therefore moves the multiplier between free values and values sign-extended from 7 and 11 bits, and compares every row, neg bit, flag and the summed product with a behavioural model on every clock.

// File: rtl/booth_ppgen_pkg.sv
package booth_ppgen_pkg;

   // Selection decoded from one three-bit recoding window.
   typedef struct packed {
      logic neg;   // negate the chosen multiple
      logic one;   // take 1*X
      logic two;   // take 2*X
   } booth_sel_t;

   function automatic booth_sel_t booth_decode(input logic [2:0] win);
      booth_sel_t s;
      s = '0;
      unique case (win)
         3'b001, 3'b010: s.one = 1'b1;
         3'b011:         s.two = 1'b1;
         3'b100:         begin s.neg = 1'b1; s.two = 1'b1; end
         3'b101, 3'b110: begin s.neg = 1'b1; s.one = 1'b1; end
         default:        s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/booth_zero_detect.sv
// Looks at the multiplier alone and reports whether the upper digit ranges
// all decode to zero. Rows >= R are zero exactly when y[W-1 : 2R-1] agree.
module booth_zero_detect #(
   parameter int WIDTH       = 16,
   parameter int WIDE_FROM   = 4,
   parameter int NARROW_FROM = 6
) (
   input  logic [WIDTH-1:0] mplier,
   output logic             wide_zero,
   output logic             narrow_zero
);
   localparam int WLO = 2*WIDE_FROM - 1;
   localparam int NLO = 2*NARROW_FROM - 1;

   logic wide_all, narrow_all;

   assign wide_all    = (&mplier[WIDTH-1:WLO]) | ~(|mplier[WIDTH-1:WLO]);
   assign narrow_all  = (&mplier[WIDTH-1:NLO]) | ~(|mplier[WIDTH-1:NLO]);
   assign wide_zero   = wide_all;
   assign narrow_zero = narrow_all & ~wide_all;
endmodule

// File: rtl/booth_row.sv
// One partial-product row: enable-controlled operand register followed by the
// multiple selector, conditional inversion and sign extension.
module booth_row
   import booth_ppgen_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int ROW   = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_en,
   input  logic                 frozen,
   input  logic [WIDTH-1:0]     mcand,
   input  logic [2:0]           win,
   output logic [2*WIDTH-1:0]   pp,
   output logic                 neg
);
   localparam int PW    = 2*WIDTH;
   localparam int SHIFT = 2*ROW;

   logic [WIDTH-1:0] x_q;
   logic [2:0]       win_q;
   booth_sel_t       sel;
   logic [WIDTH:0]   mag;
   logic [WIDTH:0]   body;
   logic [PW-1:0]    ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q   <= '0;
         win_q <= '0;
      end else if (load_en) begin
         x_q   <= mcand;
         win_q <= win;
      end
   end

   always_comb begin
      sel = booth_decode(win_q);
      if (sel.two)
         mag = {x_q, 1'b0};
      else if (sel.one)
         mag = {x_q[WIDTH-1], x_q};
      else
         mag = '0;
      body = sel.neg ? ~mag : mag;
      ext  = {{(PW-WIDTH-1){body[WIDTH]}}, body};
   end

   assign pp  = frozen ? '0 : (ext << SHIFT);
   assign neg = ~frozen & sel.neg;
endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
   import booth_ppgen_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter bit GATING      = 1'b1,
   parameter int WIDE_FROM   = 4,
   parameter int NARROW_FROM = 6
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [WIDTH-1:0]                    mcand,
   input  logic [WIDTH-1:0]                    mplier,
   output logic [WIDTH/2-1:0][2*WIDTH-1:0]     pp_rows,
   output logic [WIDTH/2-1:0]                  neg_bits,
   output logic                                gate_wide,
   output logic                                gate_narrow
);
   localparam int ROWS = WIDTH/2;

   if ((WIDTH % 2) != 0 || WIDTH < 8) begin : g_bad_width
      $error("booth_ppgen: WIDTH must be even and at least 8");
   end
   if (WIDE_FROM < 1 || NARROW_FROM <= WIDE_FROM || NARROW_FROM >= ROWS) begin : g_bad_split
      $error("booth_ppgen: need 1 <= WIDE_FROM < NARROW_FROM < ROWS");
   end

   logic [WIDTH:0] y_ext;
   logic           wide_d, narrow_d;

   assign y_ext = {mplier, 1'b0};

   if (GATING) begin : g_gate
      booth_zero_detect #(
         .WIDTH(WIDTH), .WIDE_FROM(WIDE_FROM), .NARROW_FROM(NARROW_FROM)
      ) i_detect (
         .mplier(mplier), .wide_zero(wide_d), .narrow_zero(narrow_d)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gate_wide   <= 1'b0;
            gate_narrow <= 1'b0;
         end else begin
            gate_wide   <= wide_d;
            gate_narrow <= narrow_d;
         end
      end
   end else begin : g_nogate
      assign wide_d      = 1'b0;
      assign narrow_d    = 1'b0;
      assign gate_wide   = 1'b0;
      assign gate_narrow = 1'b0;
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam bit IN_WIDE   = (r >= WIDE_FROM);
      localparam bit IN_NARROW = (r >= NARROW_FROM);

      logic load_en, frozen;

      assign load_en = ~((IN_WIDE & wide_d) | (IN_NARROW & (wide_d | narrow_d)));
      assign frozen  = (IN_WIDE & gate_wide) | (IN_NARROW & (gate_wide | gate_narrow));

      booth_row #(.WIDTH(WIDTH), .ROW(r)) i_row (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_en(load_en),
         .frozen (frozen),
         .mcand  (mcand),
         .win    (y_ext[2*r+2:2*r]),
         .pp     (pp_rows[r]),
         .neg    (neg_bits[r])
      );
   end
endmodule

// File: rtl/booth_ppgen_chk.sv
module booth_ppgen_chk #(
   parameter int WIDTH       = 16,
   parameter bit GATING      = 1'b1,
   parameter int WIDE_FROM   = 4,
   parameter int NARROW_FROM = 6
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [WIDTH-1:0]                 mplier,
   input logic [WIDTH/2-1:0][2*WIDTH-1:0]  pp_rows,
   input logic [WIDTH/2-1:0]               neg_bits,
   input logic                             gate_wide,
   input logic                             gate_narrow
);
   localparam int ROWS = WIDTH/2;
   localparam int WLO  = 2*WIDE_FROM - 1;
   localparam int NLO  = 2*NARROW_FROM - 1;

   logic up_wide, up_narrow;
   assign up_wide   = (&mplier[WIDTH-1:WLO]) | ~(|mplier[WIDTH-1:WLO]);
   assign up_narrow = ((&mplier[WIDTH-1:NLO]) | ~(|mplier[WIDTH-1:NLO])) & ~up_wide;

   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gate_wide, gate_narrow}));

   if (GATING) begin : g_flag_chk
      assert_wide_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         up_wide |=> gate_wide);
      assert_narrow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
         up_narrow |=> gate_narrow);
   end else begin : g_flag_off
      assert_no_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !gate_wide && !gate_narrow);
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_rows
      if (r >= WIDE_FROM) begin : g_w
         assert_wide_rows_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            gate_wide |-> (pp_rows[r] == '0) && !neg_bits[r]);
      end
      if (r >= NARROW_FROM) begin : g_n
         assert_narrow_rows_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            gate_narrow |-> (pp_rows[r] == '0) && !neg_bits[r]);
      end
   end
endmodule

bind booth_ppgen booth_ppgen_chk #(
   .WIDTH(WIDTH), .GATING(GATING), .WIDE_FROM(WIDE_FROM), .NARROW_FROM(NARROW_FROM)
) i_chk (
   .clk(clk), .rst_n(rst_n), .mplier(mplier), .pp_rows(pp_rows),
   .neg_bits(neg_bits), .gate_wide(gate_wide), .gate_narrow(gate_narrow)
);

// File: tb/test_booth_ppgen.sv
`timescale 1ns/1ps
module test_booth_ppgen;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       mcand = '0;
   logic [15:0]       mplier = '0;
   logic [7:0][31:0]  pp_rows;
   logic [7:0]        neg_bits;
   logic              gate_wide, gate_narrow;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   booth_ppgen i_booth_ppgen (
      .clk(clk), .rst_n(rst_n), .mcand(mcand), .mplier(mplier),
      .pp_rows(pp_rows), .neg_bits(neg_bits),
      .gate_wide(gate_wide), .gate_narrow(gate_narrow)
   );

   // Behavioural model state: operands seen at the last rising edge.
   bit          m_rst = 1;
   logic [15:0] mx = '0, my = '0;
   always @(posedge clk) begin
      m_rst = !rst_n;
      if (rst_n) begin mx = mcand; my = mplier; end
   end

   function automatic bit exp_wide(logic [15:0] y);
      return (y[15:7] == 9'h000) || (y[15:7] == 9'h1FF);
   endfunction
   function automatic bit exp_narrow(logic [15:0] y);
      return ((y[15:11] == 5'h00) || (y[15:11] == 5'h1F)) && !exp_wide(y);
   endfunction

   function automatic logic [31:0] exp_row(int i, logic [15:0] x, logic [15:0] y, output bit n);
      int d, b0, b1, b2;
      longint v;
      n  = 0;
      b2 = int'(y[2*i+1]);
      b1 = int'(y[2*i]);
      b0 = (i == 0) ? 0 : int'(y[2*i-1]);
      d  = -2*b2 + b1 + b0;
      if ((i >= 4 && exp_wide(y)) || (i >= 6 && exp_narrow(y))) return 32'd0;
      v = longint'($signed(x)) * longint'((d < 0) ? -d : d);
      if (d < 0) begin n = 1; return 32'(~v << (2*i)); end
      return 32'(v << (2*i));
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h x=%h y=%h t=%0t", tag, act, exp, mx, my, $time);
      end
   endtask

   task automatic compare_all();
      bit n;
      logic [31:0] e, s;
      for (int i = 0; i < 8; i++) begin
         e = m_rst ? 32'd0 : exp_row(i, mx, my, n);
         if (m_rst) n = 0;
         chk(m_rst ? "R9 row" : "R3 row", pp_rows[i], e);
         chk(m_rst ? "R9 neg" : "R3 neg", 32'(neg_bits[i]), 32'(n));
      end
      chk(m_rst ? "R9 gate_wide" : "R6 gate_wide", 32'(gate_wide), m_rst ? 0 : 32'(exp_wide(my)));
      chk(m_rst ? "R9 gate_narrow" : "R7 gate_narrow", 32'(gate_narrow), m_rst ? 0 : 32'(exp_narrow(my)));
      chk("R8 exclusive", 32'(gate_wide & gate_narrow), 32'd0);
      if (!m_rst) begin
         s = '0;
         for (int i = 0; i < 8; i++) s = s + pp_rows[i] + (32'(neg_bits[i]) << (2*i));
         chk("R4 product", s, 32'(longint'($signed(mx)) * longint'($signed(my))));
      end
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
   endtask

   task automatic drive(logic [15:0] x, logic [15:0] y);
      mcand = x; mplier = y;
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         done = 1; total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] rx, ry;
      drive(16'h1234, 16'h5678);
      repeat (3) tick();                       // R9 checks under reset
      rst_n = 1'b1;

      drive(16'd5, 16'd1);  tick();            // R1: row 0 from {y1,y0,0}
      chk("R1 row0 is +X", pp_rows[0], 32'd5);
      drive(16'd5, 16'd6);  tick();            // R2: windows 100 -> -2, 011 -> +2
      chk("R2 row0 -2X inverted", pp_rows[0], 32'hFFFF_FFF5);
      chk("R2 neg0", 32'(neg_bits[0]), 32'd1);
      chk("R2 row1 +2X weighted", pp_rows[1], 32'd40);
      drive(16'd7, 16'd1);                     // R5: no change before edge
      #1 chk("R5 hold until edge", pp_rows[0], 32'hFFFF_FFF5);
      tick();
      chk("R5 one-cycle latency", pp_rows[0], 32'd7);
      drive(16'd3, 16'hFF80); tick();
      chk("R6 wide flag", 32'(gate_wide), 32'd1);
      chk("R6 row7 zero", pp_rows[7], 32'd0);
      drive(16'd3, 16'h0400); tick();
      chk("R7 narrow flag", 32'(gate_narrow), 32'd1);
      chk("R7 row5 live", pp_rows[5], 32'd3072);
      drive(16'd9, 16'h0000); tick();
      drive(16'd9, 16'h4000); tick();
      chk("R10 row7 after unfreeze", pp_rows[7], 32'd147456);
      chk("R10 flags dropped", 32'({gate_wide, gate_narrow}), 32'd0);

      for (int k = 0; k < 3000; k++) begin
         rx = 16'($urandom);
         ry = 16'($urandom);
         case ($urandom % 4)
            0: ry = {{9{ry[6]}}, ry[6:0]};     // upper four rows zero
            1: ry = {{5{ry[10]}}, ry[10:0]};   // at least top two rows zero
            default: ;
         endcase
         if (k % 97 == 0) rx = (k % 2) ? 16'h8000 : 16'h7FFF;
         if (k % 89 == 0) ry = 16'h8000;
         drive(rx, ry);
         tick();
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule